// File: doc/BRIEF.md
# Shared Tri-State Bus Datapath

This block is a byte-wide datapath in which four general registers, a two-operand adder and an external data entry point all hang off one common bus. Every source reaches the bus through its own tri-state driver. The controller raises drive enables to pick the source for a cycle. It raises load enables to pick which destinations capture the bus at the next rising clock edge. When no drive enable is high, nothing drives the bus and it floats.

Moving data between registers takes one cycle: one source drives and any set of destinations loads. The adder holds two operand latches that are filled from the bus. An addition therefore takes several bus cycles: each operand is placed on the bus and latched, and then the adder drives the sum back onto the bus so a register can load it. When two or more drive enables are raised together, the block reports contention on a combinational flag. Decode and sequencing sit outside the block, and its control lines are driven directly.

Top module: `shared_bus_datapath`

## Requirements
- R1: A synchronous active-high reset clears all four registers and both adder operand latches. After reset every register reads zero, and the adder drives zero.
- R2: When exactly one drive enable is high, `bus_value` equals that source's value in the same cycle. The drive_en bits are: bits 0 to 3 for registers 0 to 3, bit 4 for the adder result, bit 5 for `ext_data`.
- R3: Register i (load_en bit i, i = 0..3) takes the bus value at the rising edge when its load bit is high. A register whose load bit is low keeps its contents.
- R4: Several destinations with their load bits high at the same edge all capture the same bus value.
- R5: Adder operand latch A (load_en bit 4) and operand latch B (load_en bit 5) each capture the bus at the rising edge when their own load bit is high.
- R6: The adder result driven onto the bus is (A + B) modulo 256.
- R7: `contention` is high exactly when two or more drive_en bits are high. It is low when none or one is high.
- R8: Reset takes priority over any load enable raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_en | input | 6 | One drive enable per bus source |
| load_en | input | 6 | One load enable per destination |
| ext_data | input | 8 | Value placed on the bus by the external source |
| bus_value | output | 8 | Resolved value of the shared bus |
| reg_view | output | 32 | Contents of registers 0..3, register i at bits 8i+7:8i |
| contention | output | 1 | High when more than one source drives |

## Verification
The transfers are tried in several forms: external data into one register, one value broadcast to two registers, register-to-latch moves, and adder results written back. Together these separate a wrong source select from a wrong destination capture. Two additions are run. One has a sum below 256 and one wraps past 255, which shows whether the result is truncated modulo 256. Contention is tried with no driver, with one driver, with two drivers and with all six, so a flag that counts incorrectly is caught. A reset raised while every load enable is high shows whether reset wins over the loads.

// File: rtl/bus_dp_pkg.sv
package bus_dp_pkg;
    localparam int DATA_W    = 8;
    localparam int REG_COUNT = 4;

    function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b);
        logic [DATA_W:0] full;
        full = {1'b0, a} + {1'b0, b};
        return full[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/bus_tri_driver.sv
module bus_tri_driver #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] d,
    output tri   [W-1:0] bus
);
    assign bus = en ? d : {W{1'bz}};
endmodule

// File: rtl/bus_load_reg.sv
module bus_load_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= d;
    end
endmodule

// File: rtl/bus_adder_unit.sv
module bus_adder_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_a,
    input  logic         ld_b,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] sum
);
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [W:0]   full;

    bus_load_reg #(.W(W)) u_opnd_a (.clk(clk), .rst(rst), .ld(ld_a), .d(bus_in), .q(opnd_a));
    bus_load_reg #(.W(W)) u_opnd_b (.clk(clk), .rst(rst), .ld(ld_b), .d(bus_in), .q(opnd_b));

    always_comb begin
        full = {1'b0, opnd_a} + {1'b0, opnd_b};
        sum  = full[W-1:0];
    end
endmodule

// File: rtl/bus_contention_detect.sv
module bus_contention_detect #(
    parameter int N = 6
) (
    input  logic [N-1:0] drv,
    output logic         multi
);
    localparam int CW = $clog2(N + 1);
    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++)
            cnt = cnt + CW'(drv[i]);
        multi = (cnt > CW'(1));
    end
endmodule

// File: rtl/shared_bus_datapath.sv
module shared_bus_datapath #(
    parameter int W        = bus_dp_pkg::DATA_W,
    parameter int NUM_REGS = bus_dp_pkg::REG_COUNT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_REGS+1:0]   drive_en,
    input  logic [NUM_REGS+1:0]   load_en,
    input  logic [W-1:0]          ext_data,
    output logic [W-1:0]          bus_value,
    output logic [NUM_REGS*W-1:0] reg_view,
    output logic                  contention
);
    localparam int SRC_N    = NUM_REGS + 2;
    localparam int ALU_SRC  = NUM_REGS;
    localparam int EXT_SRC  = NUM_REGS + 1;
    localparam int OPA_DST  = NUM_REGS;
    localparam int OPB_DST  = NUM_REGS + 1;

    tri   [W-1:0] shared_bus;
    logic [W-1:0] alu_sum;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [W-1:0] q;
        bus_load_reg #(.W(W)) u_reg (
            .clk(clk), .rst(rst), .ld(load_en[g]), .d(bus_value), .q(q)
        );
        bus_tri_driver #(.W(W)) u_drv (
            .en(drive_en[g]), .d(q), .bus(shared_bus)
        );
        assign reg_view[g*W +: W] = q;
    end

    bus_adder_unit #(.W(W)) u_alu (
        .clk(clk), .rst(rst),
        .ld_a(load_en[OPA_DST]), .ld_b(load_en[OPB_DST]),
        .bus_in(bus_value), .sum(alu_sum)
    );

    bus_tri_driver #(.W(W)) u_alu_drv (
        .en(drive_en[ALU_SRC]), .d(alu_sum), .bus(shared_bus)
    );

    bus_tri_driver #(.W(W)) u_ext_drv (
        .en(drive_en[EXT_SRC]), .d(ext_data), .bus(shared_bus)
    );

    bus_contention_detect #(.N(SRC_N)) u_cont (
        .drv(drive_en), .multi(contention)
    );

    assign bus_value = shared_bus;
endmodule

// File: rtl/shared_bus_datapath_chk.sv
module shared_bus_datapath_chk #(
    parameter int W        = 8,
    parameter int NUM_REGS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_REGS+1:0]   drive_en,
    input logic [NUM_REGS+1:0]   load_en,
    input logic [W-1:0]          ext_data,
    input logic [W-1:0]          bus_value,
    input logic [NUM_REGS*W-1:0] reg_view,
    input logic                  contention
);
    localparam int EXT_SRC = NUM_REGS + 1;

    AST_EXT_ECHO: assert property (@(posedge clk) disable iff (rst)
        (drive_en == (NUM_REGS+2)'(1 << EXT_SRC)) |-> (bus_value == ext_data)); // R2

    AST_CONTENTION_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($countones(drive_en) >= 2) |-> contention); // R7

    AST_CONTENTION_LOW: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive_en) |-> !contention); // R7

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            (load_en[g] && $countones(drive_en) == 1) |=> (reg_view[g*W +: W] == $past(bus_value))); // R3

        AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
            !load_en[g] |=> $stable(reg_view[g*W +: W])); // R3
    end
endmodule

bind shared_bus_datapath shared_bus_datapath_chk #(.W(W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst(rst), .drive_en(drive_en), .load_en(load_en),
    .ext_data(ext_data), .bus_value(bus_value), .reg_view(reg_view),
    .contention(contention)
);

// File: tb/shared_bus_datapath_bench.sv
module shared_bus_datapath_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  drive_en;
    logic [5:0]  load_en;
    logic [7:0]  ext_data;
    logic [7:0]  bus_value;
    logic [31:0] reg_view;
    logic        contention;

    int compared   = 0;
    int mismatched = 0;
    logic [7:0] model [4];

    always #10 clk = ~clk;

    shared_bus_datapath u_shared_bus_datapath (
        .clk(clk), .rst(rst), .drive_en(drive_en), .load_en(load_en),
        .ext_data(ext_data), .bus_value(bus_value), .reg_view(reg_view),
        .contention(contention)
    );

    typedef struct packed {
        logic [5:0] drv;
        logic [5:0] ld;
        logic [7:0] ext;
        logic       chk_bus;
        logic [7:0] exp_bus;
        logic       exp_cont;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t ROWS [NROWS] = '{
        '{6'b100000, 6'b000001, 8'h3C, 1'b1, 8'h3C, 1'b0},  // ext -> R0
        '{6'b100000, 6'b000110, 8'hA5, 1'b1, 8'hA5, 1'b0},  // ext -> R1,R2 broadcast (R4)
        '{6'b000001, 6'b010000, 8'h00, 1'b1, 8'h3C, 1'b0},  // R0 -> A (R5)
        '{6'b000010, 6'b100000, 8'h00, 1'b1, 8'hA5, 1'b0},  // R1 -> B (R5)
        '{6'b010000, 6'b001000, 8'h00, 1'b1, 8'hE1, 1'b0},  // sum -> R3 (R6)
        '{6'b100000, 6'b010000, 8'hF0, 1'b1, 8'hF0, 1'b0},  // ext -> A
        '{6'b100000, 6'b100000, 8'h20, 1'b1, 8'h20, 1'b0},  // ext -> B
        '{6'b010000, 6'b000001, 8'h00, 1'b1, 8'h10, 1'b0},  // wrapped sum -> R0 (R6)
        '{6'b000000, 6'b000000, 8'h00, 1'b0, 8'h00, 1'b0},  // idle bus
        '{6'b001100, 6'b000000, 8'h00, 1'b0, 8'h00, 1'b1},  // two drivers
        '{6'b111111, 6'b000000, 8'h00, 1'b0, 8'h00, 1'b1},  // all drivers
        '{6'b001000, 6'b000100, 8'h00, 1'b1, 8'hE1, 1'b0}   // R3 -> R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_view();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    initial begin
        #1000000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst = 1'b1; drive_en = '0; load_en = '0; ext_data = '0;
        for (int i = 0; i < 4; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state of registers and adder
        check("R1", reg_view, 32'h0);
        drive_en = 6'b010000;
        #5 check("R1", bus_value, 32'h0);

        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk);
            drive_en = ROWS[r].drv;
            load_en  = ROWS[r].ld;
            ext_data = ROWS[r].ext;
            #5;
            if (ROWS[r].chk_bus)
                check(ROWS[r].drv[4] ? "R6" : "R2", bus_value, ROWS[r].exp_bus);
            check("R7", contention, ROWS[r].exp_cont);
            @(posedge clk);
            if (ROWS[r].chk_bus)
                for (int k = 0; k < 4; k++)
                    if (ROWS[r].ld[k]) model[k] = ROWS[r].exp_bus;
            #5;
            check((ROWS[r].ld[3:0] == 4'b0110) ? "R4" : "R3", reg_view, model_view());
        end
        check("R3", reg_view, 32'hE1E1_A510);

        // R5: operand latches read back through the adder, B cleared by loading zero
        @(negedge clk);
        drive_en = 6'b100000; load_en = 6'b100000; ext_data = 8'h00;
        @(negedge clk);
        drive_en = 6'b010000; load_en = 6'b000000;
        #5 check("R5", bus_value, 32'hF0);

        // R8: reset wins over every load enable
        @(negedge clk);
        rst = 1'b1; drive_en = 6'b100000; load_en = 6'b111111; ext_data = 8'h77;
        @(negedge clk);
        rst = 1'b0; drive_en = 6'b010000; load_en = '0;
        check("R8", reg_view, 32'h0);
        #5 check("R8", bus_value, 32'h0);

        // R7: single driver gives no contention
        @(negedge clk);
        drive_en = 6'b000100;
        #5 check("R7", contention, 32'h0);
        @(negedge clk);
        drive_en = 6'b110000;
        #5 check("R7", contention, 32'h1);
        @(negedge clk);
        drive_en = '0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule